// File: doc/BRIEF.md
# In-Band Scan Configuration Pipeline with Shadowed Router Selects

This block sits between the scan input channels of a chip and the cores behind them. It lets the selects of the input and output channel routers be loaded without any dedicated configuration pins. Each channel passes through a short chain of flip-flops before it reaches the core. While a pattern shifts, test data streams through that chain. When the shift ends, the final bits left in the chain form that channel's router configuration.

A single-cycle update strobe, issued at the move from shifting to capture, copies every chain into a shadow register bank. Only the shadow bank drives the router selects. The routing in force therefore stays frozen during shifting, whatever bits pass through the chains. It changes only at a pattern boundary.

The chain length per channel is IN_BITS + OUT_BITS. IN_BITS of those bits steer the input demultiplexers and OUT_BITS steer the output multiplexers. The router datapaths themselves are outside this block.

Top module: `scan_cfg_pipe`

## Requirements
- R1: With `shift_en` high, each channel's chain advances by one position per cycle, and `core_si[c]` presents the bit that entered on `scan_in[c]` exactly IN_BITS+OUT_BITS shift cycles earlier (zero if fewer shifts have occurred since reset).
- R2: With `shift_en` low, `scan_in` is ignored and both the chain contents and `core_si` stay unchanged.
- R3: Per channel, the last IN_BITS+OUT_BITS bits shifted form the configuration word. The earliest IN_BITS of them load `in_sel` for that channel, the first of them landing in its MSB. The final OUT_BITS load `out_sel`, again earliest bit in the MSB. Channel c occupies `in_sel[c*IN_BITS +: IN_BITS]` and `out_sel[c*OUT_BITS +: OUT_BITS]`.
- R4: A cycle with `update_en` high copies the chain contents as they were at that clock edge into the shadow bank, visible on the selects from the next cycle.
- R5: On every cycle with `update_en` low, `in_sel` and `out_sel` hold their value, including while bits shift through the chains and while leftover bits sit in them between patterns.
- R6: Synchronous active-low reset clears every chain and every shadow register, giving all-zero selects and zero on `core_si`.
- R7: Each channel's configuration comes only from its own `scan_in` bit; bits on one channel never reach another channel's selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock shared by chains and shadows |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Advance all chains by one bit |
| update_en | input | 1 | One-cycle strobe loading the shadow bank |
| scan_in | input | CHANNELS | Serial channel data from the chip pins |
| core_si | output | CHANNELS | Delayed channel data toward the cores |
| in_sel | output | CHANNELS*IN_BITS | Shadowed input demultiplexer selects |
| out_sel | output | CHANNELS*OUT_BITS | Shadowed output multiplexer selects |

## Verification
On every cycle the assertions check four things: the shadow bank holds without a strobe, a strobe copies exactly the chain contents, an idle cycle freezes both chain and serial output, and each chain's entry stage takes the channel bit. Reset clearing is checked on every cycle as well. The end-to-end latency of IN_BITS+OUT_BITS shifts, the bit ordering into the select fields, and channel isolation need whole shift sequences. Only the bench's scenarios show these, together with leftover bits that must not disturb the routing.

// File: rtl/scan_cfg_pkg.sv
`timescale 1ns/1ps
// Shared defaults and helpers for the in-band configuration pipeline.
package scan_cfg_pkg;
    localparam int unsigned DEF_CHANNELS = 4;
    localparam int unsigned DEF_IN_BITS  = 3;
    localparam int unsigned DEF_OUT_BITS = 2;

    // Length of one channel's configuration chain.
    function automatic int unsigned ctl_len(input int unsigned in_bits, input int unsigned out_bits);
        return in_bits + out_bits;
    endfunction
endpackage

// File: rtl/cfg_stage_chain.sv
`timescale 1ns/1ps
// Serial chain of LEN flip-flops for one scan channel.
// New bits enter at stage 0; stage LEN-1 feeds the core.
// Assumes LEN >= 1; shifts only when shift_en is high.
module cfg_stage_chain #(
    parameter int unsigned LEN = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           ser_in,
    output logic [LEN-1:0] stages,
    output logic           ser_out
);
    generate
        if (LEN == 1) begin : g_single
            // Single stage: load the channel bit on a shift.
            always_ff @(posedge clk) begin
                if (!rst_n)        stages <= '0;
                else if (shift_en) stages <= ser_in;
            end
        end else begin : g_multi
            // Multi-stage: move every bit one place toward the core.
            always_ff @(posedge clk) begin
                if (!rst_n)        stages <= '0;
                else if (shift_en) stages <= {stages[LEN-2:0], ser_in};
            end
        end
    endgenerate

    assign ser_out = stages[LEN-1];
endmodule

// File: rtl/cfg_shadow_bank.sv
`timescale 1ns/1ps
// Shadow register bank: captures a word on a load strobe, else holds.
// Assumes load is a one-cycle strobe issued between patterns.
module cfg_shadow_bank #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the chain word only on the strobe; zero default at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/scan_cfg_pipe.sv
`timescale 1ns/1ps
// Top: per-channel in-band configuration chain plus shadowed selects.
// Each channel's data passes through IN_BITS+OUT_BITS stages; at an
// update strobe the stage contents become the router selects.
// Assumes IN_BITS >= 1, OUT_BITS >= 1, CHANNELS >= 1.
module scan_cfg_pipe
    import scan_cfg_pkg::*;
#(
    parameter int unsigned CHANNELS = DEF_CHANNELS,
    parameter int unsigned IN_BITS  = DEF_IN_BITS,
    parameter int unsigned OUT_BITS = DEF_OUT_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_en,
    input  logic                         update_en,
    input  logic [CHANNELS-1:0]          scan_in,
    output logic [CHANNELS-1:0]          core_si,
    output logic [CHANNELS*IN_BITS-1:0]  in_sel,
    output logic [CHANNELS*OUT_BITS-1:0] out_sel
);
    localparam int unsigned CTL_LEN = ctl_len(IN_BITS, OUT_BITS);
    localparam int unsigned ALL_LEN = CHANNELS * CTL_LEN;

    logic [ALL_LEN-1:0] stage_word;
    logic [ALL_LEN-1:0] shadow_word;

    generate
        for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
            cfg_stage_chain #(.LEN(CTL_LEN)) chain_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (shift_en),
                .ser_in   (scan_in[ch]),
                .stages   (stage_word[ch*CTL_LEN +: CTL_LEN]),
                .ser_out  (core_si[ch])
            );

            cfg_shadow_bank #(.W(CTL_LEN)) shadow_i (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (update_en),
                .d     (stage_word[ch*CTL_LEN +: CTL_LEN]),
                .q     (shadow_word[ch*CTL_LEN +: CTL_LEN])
            );

            // Earlier-shifted bits sit higher: input selects take the top field.
            assign in_sel[ch*IN_BITS +: IN_BITS]   = shadow_word[ch*CTL_LEN + OUT_BITS +: IN_BITS];
            assign out_sel[ch*OUT_BITS +: OUT_BITS] = shadow_word[ch*CTL_LEN +: OUT_BITS];
        end
    endgenerate
endmodule

// File: rtl/scan_cfg_pipe_chk.sv
`timescale 1ns/1ps
// Checker bound into scan_cfg_pipe: relates chains, shadows and ports.
module scan_cfg_pipe_chk #(
    parameter int unsigned CHANNELS = 4,
    parameter int unsigned CTL_LEN  = 5
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           shift_en,
    input logic                           update_en,
    input logic [CHANNELS-1:0]            scan_in,
    input logic [CHANNELS-1:0]            core_si,
    input logic [CHANNELS*CTL_LEN-1:0]    stage_word,
    input logic [CHANNELS*CTL_LEN-1:0]    shadow_word
);
    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(shadow_word));

    // R4
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> (shadow_word == $past(stage_word)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(core_si) && $stable(stage_word)));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ((shadow_word == '0) && (stage_word == '0) && (core_si == '0)));

    generate
        for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_entry
            // R1
            entry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> (stage_word[ch*CTL_LEN] == $past(scan_in[ch])));
        end
    endgenerate
endmodule

bind scan_cfg_pipe scan_cfg_pipe_chk #(.CHANNELS(CHANNELS), .CTL_LEN(CTL_LEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en    (shift_en),
    .update_en   (update_en),
    .scan_in     (scan_in),
    .core_si     (core_si),
    .stage_word  (stage_word),
    .shadow_word (shadow_word)
);

// File: tb/scan_cfg_pipe_tb_top.sv
`timescale 1ns/1ps
module scan_cfg_pipe_tb_top;
    localparam int CH  = 4;
    localparam int NI  = 3;
    localparam int NO  = 2;
    localparam int L   = NI + NO;
    localparam int NROW = 4;

    // Configuration words per row: channel c owns bits [c*L +: L], MSB shifted first.
    localparam logic [CH*L-1:0] CTL_TBL [NROW] = '{20'hA5C31, 20'h0F0F3, 20'hFFFFF, 20'h6B2D4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic update_en = 1'b0;
    logic [CH-1:0] scan_in = '0;
    logic [CH-1:0] core_si;
    logic [CH*NI-1:0] in_sel;
    logic [CH*NO-1:0] out_sel;

    int total_cnt = 0;
    int fail_cnt = 0;
    bit done = 1'b0;

    logic [CH-1:0] hist [0:1023];
    int nshift = 0;
    logic [CH*NI-1:0] prev_in = '0;
    logic [CH*NO-1:0] prev_out = '0;

    always #5 clk = ~clk;

    scan_cfg_pipe #(.CHANNELS(CH), .IN_BITS(NI), .OUT_BITS(NO)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .update_en (update_en),
        .scan_in   (scan_in),
        .core_si   (core_si),
        .in_sel    (in_sel),
        .out_sel   (out_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CH-1:0] exp_core();
        if (nshift >= L) return hist[nshift-L];
        return '0;
    endfunction

    // Expected selects from the last L shifted bits (R3 ordering).
    function automatic logic [CH*NI-1:0] exp_in();
        logic [CH*NI-1:0] r = '0;
        for (int c = 0; c < CH; c++)
            for (int j = 0; j < NI; j++)
                r[c*NI + NI-1-j] = (nshift-L+j >= 0) ? hist[nshift-L+j][c] : 1'b0;
        return r;
    endfunction

    function automatic logic [CH*NO-1:0] exp_out();
        logic [CH*NO-1:0] r = '0;
        for (int c = 0; c < CH; c++)
            for (int j = 0; j < NO; j++)
                r[c*NO + NO-1-j] = (nshift-NO+j >= 0) ? hist[nshift-NO+j][c] : 1'b0;
        return r;
    endfunction

    // Called at a negedge; returns at the following negedge.
    task automatic do_shift(input logic [CH-1:0] v);
        scan_in = v;
        shift_en = 1'b1;
        hist[nshift] = v;
        @(posedge clk);
        @(negedge clk);
        shift_en = 1'b0;
        nshift++;
        chk("R1 core_si", 32'(core_si), 32'(exp_core()));
    endtask

    task automatic do_update();
        update_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        update_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        nshift = 0;
        prev_in = '0;
        prev_out = '0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fail_cnt++;
            total_cnt++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R6: reset state
        chk("R6 in_sel", 32'(in_sel), 32'h0);
        chk("R6 out_sel", 32'(out_sel), 32'h0);
        chk("R6 core_si", 32'(core_si), 32'h0);

        // Table walk: data bits, then a configuration word, then update.
        for (int r = 0; r < NROW; r++) begin
            for (int d = 0; d < 3; d++) do_shift(4'((r*3 + d) ^ 9));
            for (int j = 0; j < L; j++) begin
                logic [CH-1:0] v;
                for (int c = 0; c < CH; c++) v[c] = CTL_TBL[r][c*L + L-1-j];
                do_shift(v);
            end
            // R5: routing frozen through the whole shift
            chk("R5 in_sel held", 32'(in_sel), 32'(prev_in));
            chk("R5 out_sel held", 32'(out_sel), 32'(prev_out));
            do_update();
            // R3/R4: word from table lands in the select fields
            begin
                logic [CH*NI-1:0] ei;
                logic [CH*NO-1:0] eo;
                for (int c = 0; c < CH; c++) begin
                    ei[c*NI +: NI] = CTL_TBL[r][c*L + NO +: NI];
                    eo[c*NO +: NO] = CTL_TBL[r][c*L +: NO];
                end
                chk("R3 in_sel", 32'(in_sel), 32'(ei));
                chk("R3 out_sel", 32'(out_sel), 32'(eo));
                chk("R4 in_sel model", 32'(in_sel), 32'(exp_in()));
                prev_in = ei;
                prev_out = eo;
            end
            chk("R2 core_si after update", 32'(core_si), 32'(exp_core()));
        end

        // R2: idle cycles ignore scan_in
        for (int k = 0; k < 3; k++) begin
            scan_in = 4'(k * 5 + 3);
            @(posedge clk);
            @(negedge clk);
            chk("R2 core_si idle", 32'(core_si), 32'(exp_core()));
        end
        do_shift(4'hF);
        chk("R2 resumes after idle", 32'(core_si), 32'(hist[nshift-L]));

        // R5: leftover bits in the chain do not touch the routing
        do_shift(4'h5);
        do_shift(4'hA);
        chk("R5 leftover in_sel", 32'(in_sel), 32'(prev_in));
        chk("R5 leftover out_sel", 32'(out_sel), 32'(prev_out));
        do_update();
        chk("R4 mixed in_sel", 32'(in_sel), 32'(exp_in()));
        chk("R4 mixed out_sel", 32'(out_sel), 32'(exp_out()));
        prev_in = in_sel;
        prev_out = out_sel;
        // R4: a second strobe with no shift reloads the same word
        do_update();
        chk("R4 repeat in_sel", 32'(in_sel), 32'(prev_in));
        chk("R4 repeat out_sel", 32'(out_sel), 32'(prev_out));

        // R6: reset mid-run clears selects and chain
        do_reset();
        chk("R6 mid in_sel", 32'(in_sel), 32'h0);
        chk("R6 mid out_sel", 32'(out_sel), 32'h0);
        chk("R6 mid core_si", 32'(core_si), 32'h0);

        // R7: only channel 2 carries ones; fields of others stay zero
        for (int j = 0; j < L; j++) do_shift(4'b0100);
        do_update();
        chk("R7 in_sel isolation", 32'(in_sel), 32'h1C0);
        chk("R7 out_sel isolation", 32'(out_sel), 32'h30);

        done = 1'b1;
        $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
        $finish;
    end
endmodule